// File: doc/BRIEF.md
# GPIO Pin Interrupt Trigger and Status Cell

This block sits behind each general-purpose pin, after the glitch filter and ahead of the bank-wide interrupt collector. It watches the filtered pin level. It decides from per-pin configuration fields whether a level or an edge of a given polarity counts as an event, and records events in sticky status bits. From those bits it drives a per-pin interrupt request and a per-pin service flag toward the collector. A whole group of `NUM_PINS` pins is built as one array of identical cells.

Each pin has its own configuration. A trigger-type bit selects level sensing or edge sensing, and a two-bit polarity code picks low/falling, high/rising or both edges. Detection is gated by an enable bit. The request leaving the block is gated separately by an unmask bit. A wake-enable bit lets the same event also set a wake status bit. Software clears status with a write-one-to-clear port: it names a pin and carries one data bit per status flag. Writing back the value just read therefore clears whatever was pending.

Top module: `gpio_irq_trigger`

## Requirements
- R1: While `rst` is high, and in the cycle after it, every status bit, every request, every service flag and every `pin_sts` bit is 0.
- R2: With the trigger-type bit at 0 (edge) and polarity code 01, a low-to-high change of `pin_lvl` sets `int_sts` one clock later if the enable bit is 1. The bit stays set after the input falls again.
- R3: With edge mode and polarity code 00, only a high-to-low change sets `int_sts`. A rising change does not.
- R4: With edge mode and polarity code 10, both rising and falling changes set `int_sts`.
- R5: With the trigger-type bit at 1 (level), code 01 sets `int_sts` in every cycle the input is high and code 00 in every cycle it is low. So a clear has no effect while the level stays active. After the input leaves the active level, the bit stays set until it is cleared.
- R6: Polarity code 11 never sets any status bit, in either trigger type.
- R7: With the enable bit at 0, no new `int_sts` is set. A bit that is already set stays set.
- R8: `irq_req` of a pin is high exactly when its `int_sts` is high and its unmask bit is 1.
- R9: One cycle with `clr_we` high clears `int_sts` (when `clr_int` is 1) and `wake_sts` (when `clr_wake` is 1) of the pin numbered `clr_pin` only. A 0 data bit, another pin number, or a number at or above `NUM_PINS` leaves the status unchanged. An event in the same cycle as a clear wins, and the bit stays set.
- R10: An event with the wake-enable bit at 1 sets `wake_sts`, whether or not the enable bit is set. `svc_req` is high when `int_sts` or `wake_sts` is high.
- R11: `pin_sts` shows the `pin_lvl` value sampled at the previous clock edge.
- R12: The first clock edge after reset is released never counts as an edge, even if the input is already high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pin_lvl | input | NUM_PINS | Filtered pin levels |
| cfg_lvl_mode | input | NUM_PINS | Trigger type per pin: 1 level, 0 edge |
| cfg_pol | input | 2*NUM_PINS | Polarity code per pin, pin i at bits 2i+1:2i (00 low/fall, 01 high/rise, 10 both edges, 11 none) |
| cfg_en | input | NUM_PINS | Detection enable per pin |
| cfg_unmask | input | NUM_PINS | Delivery enable per pin, 1 = unmasked |
| cfg_wake_en | input | NUM_PINS | Wake status enable per pin |
| clr_we | input | 1 | Status clear strobe |
| clr_pin | input | idx_w(NUM_PINS) | Pin number addressed by the clear |
| clr_int | input | 1 | Write 1 to clear interrupt status |
| clr_wake | input | 1 | Write 1 to clear wake status |
| int_sts | output | NUM_PINS | Sticky interrupt status |
| wake_sts | output | NUM_PINS | Sticky wake status |
| pin_sts | output | NUM_PINS | Registered pin level |
| irq_req | output | NUM_PINS | Unmasked interrupt request |
| svc_req | output | NUM_PINS | Pin needs service (interrupt or wake) |

## Verification
The bench builds the block with `NUM_PINS` set to 3. This makes the clear index two bits wide while leaving code 3 unused, so the bench can write to a pin number that does not exist and confirm that nothing changes. It also lets the bench drive the highest pin while the lower pins sit in other modes, which shows that events and clears stay on their own pin. Most sequences run on pin 0 and step through every polarity code in both trigger types. They also cover a set and a clear arriving in the same cycle.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    typedef enum logic [1:0] {
        POL_LOW  = 2'b00,
        POL_HIGH = 2'b01,
        POL_BOTH = 2'b10,
        POL_NONE = 2'b11
    } pol_e;

    typedef struct packed {
        logic lvl_mode;
        pol_e pol;
        logic en;
        logic unmask;
        logic wake_en;
    } pin_cfg_t;

    typedef struct packed {
        logic int_sts;
        logic wake_sts;
    } pin_flags_t;

    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // Decide whether the current sample is a trigger event.
    function automatic logic trig_hit(input logic lvl_mode, input pol_e pol,
                                      input logic cur, input logic prev,
                                      input logic primed);
        logic rise;
        logic fall;
        logic res;
        rise = cur & ~prev & primed;
        fall = ~cur & prev & primed;
        res  = 1'b0;
        if (lvl_mode) begin
            case (pol)
                POL_LOW:  res = ~cur;
                POL_HIGH: res = cur;
                default:  res = 1'b0;
            endcase
        end else begin
            case (pol)
                POL_LOW:  res = fall;
                POL_HIGH: res = rise;
                POL_BOTH: res = rise | fall;
                default:  res = 1'b0;
            endcase
        end
        return res;
    endfunction

endpackage

// File: rtl/gpio_trig_detect.sv
module gpio_trig_detect
    import gpio_irq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic pin_lvl,
    input  logic lvl_mode,
    input  pol_e pol,
    output logic hit,
    output logic lvl_q
);

    logic primed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q    <= 1'b0;
            primed_q <= 1'b0;
        end else begin
            lvl_q    <= pin_lvl;
            primed_q <= 1'b1;
        end
    end

    always_comb begin
        hit = trig_hit(lvl_mode, pol, pin_lvl, lvl_q, primed_q);
    end

    // R6
    rsvd_code_silent_chk: assert property (@(posedge clk) disable iff (rst)
        (pol == POL_NONE) |-> !hit);

    // R12
    no_edge_before_primed_chk: assert property (@(posedge clk) disable iff (rst)
        (!primed_q && !lvl_mode) |-> !hit);

endmodule

// File: rtl/gpio_sts_cell.sv
module gpio_sts_cell
    import gpio_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       hit,
    input  logic       en,
    input  logic       wake_en,
    input  logic       clr_int,
    input  logic       clr_wake,
    output pin_flags_t flags
);

    logic set_int;
    logic set_wake;

    always_comb begin
        set_int  = hit & en;
        set_wake = hit & wake_en;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
        end else begin
            flags.int_sts  <= set_int  | (flags.int_sts  & ~clr_int);
            flags.wake_sts <= set_wake | (flags.wake_sts & ~clr_wake);
        end
    end

    // R7
    off_no_new_int_chk: assert property (@(posedge clk) disable iff (rst)
        (!en && !flags.int_sts) |=> !flags.int_sts);

    // R9
    clear_takes_effect_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_int && !(hit && en)) |=> !flags.int_sts);

    // R2
    event_sets_int_chk: assert property (@(posedge clk) disable iff (rst)
        (hit && en) |=> flags.int_sts);

    // R10
    event_sets_wake_chk: assert property (@(posedge clk) disable iff (rst)
        (hit && wake_en) |=> flags.wake_sts);

endmodule

// File: rtl/gpio_irq_trigger.sv
module gpio_irq_trigger
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NUM_PINS-1:0]           pin_lvl,
    input  logic [NUM_PINS-1:0]           cfg_lvl_mode,
    input  logic [2*NUM_PINS-1:0]         cfg_pol,
    input  logic [NUM_PINS-1:0]           cfg_en,
    input  logic [NUM_PINS-1:0]           cfg_unmask,
    input  logic [NUM_PINS-1:0]           cfg_wake_en,
    input  logic                          clr_we,
    input  logic [idx_w(NUM_PINS)-1:0]    clr_pin,
    input  logic                          clr_int,
    input  logic                          clr_wake,
    output logic [NUM_PINS-1:0]           int_sts,
    output logic [NUM_PINS-1:0]           wake_sts,
    output logic [NUM_PINS-1:0]           pin_sts,
    output logic [NUM_PINS-1:0]           irq_req,
    output logic [NUM_PINS-1:0]           svc_req
);

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        pin_cfg_t   cfg;
        pin_flags_t flags;
        logic       hit;
        logic       sel;

        always_comb begin
            cfg.lvl_mode = cfg_lvl_mode[i];
            cfg.pol      = pol_e'(cfg_pol[2*i +: 2]);
            cfg.en       = cfg_en[i];
            cfg.unmask   = cfg_unmask[i];
            cfg.wake_en  = cfg_wake_en[i];
            sel          = clr_we && (int'(clr_pin) == i);
        end

        gpio_trig_detect i_detect (
            .clk      (clk),
            .rst      (rst),
            .pin_lvl  (pin_lvl[i]),
            .lvl_mode (cfg.lvl_mode),
            .pol      (cfg.pol),
            .hit      (hit),
            .lvl_q    (pin_sts[i])
        );

        gpio_sts_cell i_sts (
            .clk      (clk),
            .rst      (rst),
            .hit      (hit),
            .en       (cfg.en),
            .wake_en  (cfg.wake_en),
            .clr_int  (sel & clr_int),
            .clr_wake (sel & clr_wake),
            .flags    (flags)
        );

        always_comb begin
            int_sts[i]  = flags.int_sts;
            wake_sts[i] = flags.wake_sts;
            irq_req[i]  = flags.int_sts & cfg.unmask;
            svc_req[i]  = flags.int_sts | flags.wake_sts;
        end

        // R8
        masked_quiet_chk: assert property (@(posedge clk) disable iff (rst)
            !cfg_unmask[i] |-> !irq_req[i]);

        // R10
        wake_needs_service_chk: assert property (@(posedge clk) disable iff (rst)
            wake_sts[i] |-> svc_req[i]);
    end

endmodule

// File: tb/test_gpio_irq_trigger.sv
`timescale 1ns/1ps
module test_gpio_irq_trigger;

    localparam int N  = 3;
    localparam int IW = 2;

    typedef struct packed {
        logic [N-1:0] i;
        logic [N-1:0] w;
        logic [N-1:0] r;
        logic [N-1:0] s;
        logic [N-1:0] p;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  lvl = '0, lt = '0, en = '0, um = '0, wk = '0;
    logic [2*N-1:0] pol = '1;
    logic          clr_we = 1'b0, clr_i = 1'b0, clr_w = 1'b0;
    logic [IW-1:0] clr_pin = '0;
    logic [N-1:0]  int_sts, wake_sts, pin_sts, irq_req, svc_req;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    exp_t  q[$];
    string tq[$];

    always #4 clk = ~clk;

    gpio_irq_trigger #(.NUM_PINS(N)) i_gpio_irq_trigger (
        .clk(clk), .rst(rst), .pin_lvl(lvl), .cfg_lvl_mode(lt), .cfg_pol(pol),
        .cfg_en(en), .cfg_unmask(um), .cfg_wake_en(wk), .clr_we(clr_we),
        .clr_pin(clr_pin), .clr_int(clr_i), .clr_wake(clr_w),
        .int_sts(int_sts), .wake_sts(wake_sts), .pin_sts(pin_sts),
        .irq_req(irq_req), .svc_req(svc_req)
    );

    // Monitor: compares outputs against queued expectations.
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t  e;
            exp_t  a;
            string t;
            e = q.pop_front();
            t = tq.pop_front();
            a = '{i: int_sts, w: wake_sts, r: irq_req, s: svc_req, p: pin_sts};
            checks++;
            if (a !== e) begin
                fails++;
                $display("FAIL %s: int/wake/irq/svc/pin actual=%b/%b/%b/%b/%b expected=%b/%b/%b/%b/%b",
                         t, a.i, a.w, a.r, a.s, a.p, e.i, e.w, e.r, e.s, e.p);
            end
        end
    end

    // Driver: one clock edge, queue what the requirements predict after it.
    task automatic tick(input string tag, input logic [N-1:0] ei, input logic [N-1:0] ew);
        exp_t e;
        logic [N-1:0] p_exp;
        p_exp = rst ? '0 : lvl;
        @(posedge clk);
        e.i = ei;
        e.w = ew;
        e.r = ei & um;          // R8 rule
        e.s = ei | ew;          // R10 rule
        e.p = p_exp;            // R11 rule
        q.push_back(e);
        tq.push_back(tag);
        @(negedge clk);
        #1;
        clr_we = 1'b0;
        clr_i  = 1'b0;
        clr_w  = 1'b0;
    endtask

    task automatic clear(input logic [IW-1:0] pin, input logic ci, input logic cw);
        clr_we  = 1'b1;
        clr_pin = pin;
        clr_i   = ci;
        clr_w   = cw;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R1 watchdog: actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        // pin0: edge, rising, enabled, unmasked; others idle with code 11
        lt = 3'b000; pol = 6'b11_11_01; en = 3'b001; um = 3'b001; wk = 3'b000;
        lvl = 3'b001;
        tick("R1", 3'b000, 3'b000);
        tick("R1", 3'b000, 3'b000);
        rst = 1'b0;
        tick("R12", 3'b000, 3'b000);
        lvl = 3'b000; tick("R2 fall ignored", 3'b000, 3'b000);
        lvl = 3'b001; tick("R2 rise", 3'b001, 3'b000);
        lvl = 3'b000; tick("R2 sticky", 3'b001, 3'b000);
        um = 3'b000;  tick("R8 masked", 3'b001, 3'b000);
        um = 3'b001;  tick("R8 unmasked", 3'b001, 3'b000);
        clear(2'd0, 1'b0, 1'b1); tick("R9 zero data bit", 3'b001, 3'b000);
        clear(2'd1, 1'b1, 1'b0); tick("R9 other pin", 3'b001, 3'b000);
        clear(2'd3, 1'b1, 1'b1); tick("R9 out of range", 3'b001, 3'b000);
        clear(2'd0, 1'b1, 1'b0); tick("R9 clear", 3'b000, 3'b000);
        lvl = 3'b001; clear(2'd0, 1'b1, 1'b0); tick("R9 set wins", 3'b001, 3'b000);
        clear(2'd0, 1'b1, 1'b0); tick("R9 clear again", 3'b000, 3'b000);
        // falling
        pol[1:0] = 2'b00;
        lvl = 3'b000; tick("R3 fall", 3'b001, 3'b000);
        clear(2'd0, 1'b1, 1'b0); tick("R3 clear", 3'b000, 3'b000);
        lvl = 3'b001; tick("R3 rise ignored", 3'b000, 3'b000);
        // both edges
        pol[1:0] = 2'b10;
        lvl = 3'b000; tick("R4 fall", 3'b001, 3'b000);
        lvl = 3'b001; clear(2'd0, 1'b1, 1'b0); tick("R4 rise", 3'b001, 3'b000);
        clear(2'd0, 1'b1, 1'b0); tick("R4 clear", 3'b000, 3'b000);
        // reserved code
        pol[1:0] = 2'b11;
        lvl = 3'b000; tick("R6 edge fall", 3'b000, 3'b000);
        lvl = 3'b001; tick("R6 edge rise", 3'b000, 3'b000);
        // enable gating
        pol[1:0] = 2'b01; en = 3'b000;
        lvl = 3'b000; tick("R7 off", 3'b000, 3'b000);
        lvl = 3'b001; tick("R7 off rise", 3'b000, 3'b000);
        en = 3'b001;
        lvl = 3'b000; tick("R7 on fall", 3'b000, 3'b000);
        lvl = 3'b001; tick("R2 rise again", 3'b001, 3'b000);
        en = 3'b000;
        lvl = 3'b000; tick("R7 kept", 3'b001, 3'b000);
        clear(2'd0, 1'b1, 1'b0); tick("R7 cleared", 3'b000, 3'b000);
        // level mode
        en = 3'b001; lt = 3'b001;
        tick("R5 high inactive", 3'b000, 3'b000);
        lvl = 3'b001; tick("R5 high active", 3'b001, 3'b000);
        clear(2'd0, 1'b1, 1'b0); tick("R5 reset while active", 3'b001, 3'b000);
        lvl = 3'b000; tick("R5 held", 3'b001, 3'b000);
        clear(2'd0, 1'b1, 1'b0); tick("R5 cleared", 3'b000, 3'b000);
        pol[1:0] = 2'b00; tick("R5 low active", 3'b001, 3'b000);
        lvl = 3'b001; clear(2'd0, 1'b1, 1'b0); tick("R5 low cleared", 3'b000, 3'b000);
        pol[1:0] = 2'b11;
        lvl = 3'b000; tick("R6 level low", 3'b000, 3'b000);
        lvl = 3'b001; tick("R6 level high", 3'b000, 3'b000);
        // wake
        lt = 3'b000; pol[1:0] = 2'b01; en = 3'b000; wk = 3'b001;
        lvl = 3'b000; tick("R10 idle", 3'b000, 3'b000);
        lvl = 3'b001; tick("R10 wake", 3'b000, 3'b001);
        clear(2'd0, 1'b0, 1'b1); tick("R10 wake cleared", 3'b000, 3'b000);
        // highest pin and isolation
        wk = 3'b000; en = 3'b100; um = 3'b100; pol[5:4] = 2'b01;
        lvl = 3'b101; tick("R2 pin2", 3'b100, 3'b000);
        clear(2'd0, 1'b1, 1'b1); tick("R9 pin0 clear spares pin2", 3'b100, 3'b000);
        clear(2'd2, 1'b1, 1'b0); tick("R9 pin2 clear", 3'b000, 3'b000);
        lvl = 3'b111; tick("R11 level", 3'b000, 3'b000);
        lvl = 3'b010; tick("R11 level", 3'b000, 3'b000);
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule